// File: doc/BRIEF.md
# Reloadable Event Timer

A register-programmed down-counting timer that sits on a simple 32-bit read/write strobe bus. Software places a 64-bit start value in two word registers, then starts the timer with one control write that also picks the mode and whether the interrupt reaches the output pin. Counting advances only on cycles where the tick-enable input is high, so one clock serves both the bus and a slower tick rate.

When the count is used up, a sticky status flag is raised. In the auto-reload mode the counter restarts from the stored value and keeps producing events at a fixed period. In the single-event mode it halts until software re-arms it. Software acknowledges an event by writing one to the status flag. A parameter moves the control register between two bus offsets, so the block fits either of two address layouts.

Top module: `event_timer`

## Requirements
- R1: After reset every register reads zero, the timer is halted and `irqOut` is low.
- R2: The word at offset 0x00 holds bits 31:0 of the 64-bit start value and the word at 0x04 holds bits 63:32; both read back what was written.
- R3: The control register sits at 0x10 when `CTRL_ALT` is 0 and at 0x1C when it is 1. Only its bits 2:0 are stored and the rest read zero. A read of any other offset, including the unused control location, returns zero.
- R4: A control write that sets bit 0 while bit 0 is currently 0 loads the counter with the 64-bit start value on that edge and starts counting. A tick on that same edge is not counted.
- R5: With start value N, the event fires on the (N+1)-th tick-enable pulse after the start. The status flag (offset 0x18, bit 0) reads one from the next cycle. Cycles without tick-enable do not advance the count.
- R6: With control bit 1 = 0 (auto-reload), the counter reloads on each event, so events repeat every N+1 ticks.
- R7: With control bit 1 = 1 (single event), the timer halts after the first event and raises no further events until bit 0 is written 0 and then 1 again.
- R8: A control write with bit 0 = 0 halts the timer, and no event follows.
- R9: Writing the status register with bit 0 = 1 clears the flag and writing 0 leaves it unchanged. If a clear and an event fall on the same edge, the flag stays set.
- R10: `irqOut` is a level equal to the status flag ANDed with control bit 2. The flag still latches while bit 2 is 0.
- R11: A control write that keeps bit 0 at 1 while the timer is already running does not restart the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for bus and counter |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle count-enable pulses at the tick rate |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe; `rdData` is zero when low |
| addr | input | ADDR_W | Byte offset of the register |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Combinational read data |
| irqOut | output | 1 | Level interrupt request |

## Verification
Directed sequences cover a start value of three in auto-reload mode, which shows whether the period is N or N+1 ticks and whether the reload happens. A start value of two in single-event mode shows whether the timer halts or keeps firing. A start value of zero with a tick on every cycle lines a clear up with an event on the same edge, which tells apart the two possible priorities. A second enable write in the middle of a count shows whether it restarts the count. Seeded random traffic then mixes sparse ticks, arbitrary control words, clears and reads against a cycle model, so mode changes, masked events and a halt arriving just before an event are all hit.

// File: rtl/event_timer_pkg.sv
package event_timer_pkg;
  typedef struct packed {
    logic load;
    logic reload;
    logic dec;
  } cntStrb_t;

  localparam int unsigned OFS_LOAD_LO = 'h00;
  localparam int unsigned OFS_LOAD_HI = 'h04;
  localparam int unsigned OFS_STATUS  = 'h18;
  localparam int unsigned OFS_CTRL_A  = 'h10;
  localparam int unsigned OFS_CTRL_B  = 'h1C;

  localparam int CTRL_BITS = 3;
  localparam int BIT_EN    = 0;
  localparam int BIT_MODE  = 1;
  localparam int BIT_UNMSK = 2;
endpackage

// File: rtl/event_timer_dp.sv
module event_timer_dp
  import event_timer_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrb_t         strb,
  input  logic [CNT_W-1:0] loadVal,
  output logic             cntZero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)                        cnt <= '0;
    else if (strb.load | strb.reload) cnt <= loadVal;
    else if (strb.dec)                cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  // R4: a nonzero start value leaves the counter nonzero after the load
  p_load_nonzero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && (loadVal != '0)) |=> !cntZero);
endmodule

// File: rtl/event_timer_ctrl.sv
module event_timer_ctrl
  import event_timer_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter bit CTRL_ALT = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                cntZero,
  output logic [2*DATA_W-1:0] loadVal,
  output cntStrb_t            strb,
  output logic [DATA_W-1:0]   rdData,
  output logic                irqOut
);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(OFS_LOAD_LO);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(OFS_LOAD_HI);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_CTRL = CTRL_ALT ? ADDR_W'(OFS_CTRL_B) : ADDR_W'(OFS_CTRL_A);

  logic [DATA_W-1:0]    loadLo, loadHi;
  logic [CTRL_BITS-1:0] ctrlQ;
  logic                 statusQ, running;
  logic                 wrCtrl, wrStat, enRise, expire;

  assign wrCtrl = wrEn && (addr == A_CTRL);
  assign wrStat = wrEn && (addr == A_STAT);
  assign enRise = wrCtrl && wrData[BIT_EN] && !ctrlQ[BIT_EN];
  assign expire = running && tickEn && cntZero;

  always_comb begin
    strb.load   = enRise;
    strb.reload = expire && !ctrlQ[BIT_MODE];
    strb.dec    = running && tickEn && !cntZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadLo  <= '0;
      loadHi  <= '0;
      ctrlQ   <= '0;
      statusQ <= 1'b0;
      running <= 1'b0;
    end else begin
      if (wrEn && addr == A_LO) loadLo <= wrData;
      if (wrEn && addr == A_HI) loadHi <= wrData;
      if (wrCtrl) ctrlQ <= wrData[CTRL_BITS-1:0];
      if (enRise)                                running <= 1'b1;
      else if (wrCtrl && !wrData[BIT_EN])        running <= 1'b0;
      else if (expire && ctrlQ[BIT_MODE])        running <= 1'b0;
      if (expire)                                statusQ <= 1'b1;
      else if (wrStat && wrData[0])              statusQ <= 1'b0;
    end
  end

  assign loadVal = {loadHi, loadLo};
  assign irqOut  = statusQ & ctrlQ[BIT_UNMSK];

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (addr == A_LO)        rdData = loadLo;
      else if (addr == A_HI)   rdData = loadHi;
      else if (addr == A_CTRL) rdData = {{(DATA_W-CTRL_BITS){1'b0}}, ctrlQ};
      else if (addr == A_STAT) rdData = {{(DATA_W-1){1'b0}}, statusQ};
    end
  end

  // R5: an event leaves the status flag set
  p_event_sets_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> statusQ);
  // R9: a one written to status clears it when no event competes
  p_w1c_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && wrData[0] && !expire) |=> !statusQ);
  // R7: single-event mode halts after its event
  p_single_halts_r7: assert property (@(posedge clk) disable iff (!rstN)
    (expire && ctrlQ[BIT_MODE] && !wrCtrl) |=> !running);
  // R8: a disabling write halts the timer
  p_disable_halts_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && !wrData[BIT_EN]) |=> !running);
  // R11: re-enabling a running timer keeps it running without a reload
  p_no_retrigger_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && wrData[BIT_EN] && running && !expire) |=> (running && !$past(strb.load)));
endmodule

// File: rtl/event_timer.sv
module event_timer
  import event_timer_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter bit CTRL_ALT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  localparam int CNT_W = 2 * DATA_W;

  cntStrb_t         strb;
  logic [CNT_W-1:0] loadVal;
  logic             cntZero;

  event_timer_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ALT(CTRL_ALT)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .cntZero(cntZero), .loadVal(loadVal),
    .strb(strb), .rdData(rdData), .irqOut(irqOut)
  );

  event_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal), .cntZero(cntZero)
  );

  // R4/R6: reload and load strobes never coincide with a decrement
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !((strb.load || strb.reload) && strb.dec));
endmodule

// File: tb/event_timer_tb.sv
module event_timer_tb;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [7:0] A_CTRL = 8'h10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tickEn = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          irqOut;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  logic [31:0] mLo, mHi;
  logic [2:0]  mCtrl;
  logic        mStat, mRun;
  logic [63:0] mCnt;

  always #10 clk = ~clk;

  event_timer u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mRead(input logic [7:0] a);
    case (a)
      8'h00:   return mLo;
      8'h04:   return mHi;
      A_CTRL:  return {29'b0, mCtrl};
      8'h18:   return {31'b0, mStat};
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelReset();
    mLo = 0; mHi = 0; mCtrl = 0; mStat = 0; mRun = 0; mCnt = 0;
  endtask

  task automatic modelEdge(input logic we, input logic [7:0] a, input logic [31:0] d, input logic tk);
    logic exp, wc;
    logic [63:0] ld;
    exp = mRun && tk && (mCnt == 0);
    wc  = we && (a == A_CTRL);
    ld  = {mHi, mLo};
    if (wc && d[0] && !mCtrl[0]) mCnt = ld;
    else if (mRun && tk) begin
      if (mCnt != 0) mCnt = mCnt - 1;
      else if (!mCtrl[1]) mCnt = ld;
    end
    if (wc && d[0] && !mCtrl[0]) mRun = 1;
    else if (wc && !d[0]) mRun = 0;
    else if (exp && mCtrl[1]) mRun = 0;
    if (exp) mStat = 1;
    else if (we && a == 8'h18 && d[0]) mStat = 0;
    if (we && a == 8'h00) mLo = d;
    if (we && a == 8'h04) mHi = d;
    if (wc) mCtrl = d[2:0];
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d, input logic tk);
    wrEn = we; addr = a; wrData = d; tickEn = tk;
    @(posedge clk);
    modelEdge(we, a, d, tk);
    @(negedge clk);
    wrEn = 0; tickEn = 0;
    chk({31'b0, irqOut}, {31'b0, mStat & mCtrl[2]}, "R10 irq level");
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rdEn = 1; addr = a;
    #1;
    chk(rdData, exp, tag);
    rdEn = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 1);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [7:0] offs [6];
    offs[0] = 8'h00; offs[1] = 8'h04; offs[2] = 8'h08;
    offs[3] = 8'h10; offs[4] = 8'h18; offs[5] = 8'h1C;
    seed = $urandom(32'd2024);
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 6; i++) rd(offs[i], 32'h0, "R1 reset read");
    chk({31'b0, irqOut}, 0, "R1 irq after reset");

    // R2/R3: readback and layout
    step(1, 8'h00, 32'hA5A5_0003, 0);
    step(1, 8'h04, 32'h0000_0000, 0);
    rd(8'h00, 32'hA5A5_0003, "R2 low word");
    step(1, 8'h04, 32'h1234_5678, 0);
    rd(8'h04, 32'h1234_5678, "R2 high word");
    step(1, A_CTRL, 32'hFFFF_FFF6, 0);
    rd(A_CTRL, 32'h6, "R3 ctrl bits only");
    rd(8'h1C, 32'h0, "R3 other ctrl slot reads zero");
    rd(8'h08, 32'h0, "R3 unmapped reads zero");
    step(1, A_CTRL, 0, 0);
    step(1, 8'h04, 0, 0);
    step(1, 8'h00, 3, 0);

    // R4/R5/R6: auto-reload with N=3, tick on enable edge ignored
    step(1, A_CTRL, 32'h5, 1);
    ticks(3);
    chk({31'b0, irqOut}, 0, "R5 no event before N+1 ticks");
    step(0, 8'h00, 0, 0); step(0, 8'h00, 0, 0);
    chk({31'b0, irqOut}, 0, "R5 idle cycles do not count");
    ticks(1);
    chk({31'b0, irqOut}, 1, "R5 event on tick N+1");
    step(1, 8'h18, 0, 0);
    rd(8'h18, 1, "R9 write of zero keeps flag");
    step(1, 8'h18, 1, 0);
    rd(8'h18, 0, "R9 write of one clears flag");
    ticks(3);
    chk({31'b0, irqOut}, 0, "R6 no early reload event");
    ticks(1);
    chk({31'b0, irqOut}, 1, "R6 periodic event");
    step(1, 8'h18, 1, 0);

    // R11: rewrite enable mid-count
    ticks(2);
    step(1, A_CTRL, 32'h5, 0);
    ticks(1);
    chk({31'b0, irqOut}, 0, "R11 before end of period");
    ticks(1);
    chk({31'b0, irqOut}, 1, "R11 count not restarted");

    // R8: disable halts
    step(1, A_CTRL, 0, 0);
    step(1, 8'h18, 1, 0);
    ticks(8);
    rd(8'h18, 0, "R8 no event after disable");

    // R7: single-event mode N=2
    step(1, 8'h00, 2, 0);
    step(1, A_CTRL, 32'h7, 0);
    ticks(3);
    chk({31'b0, irqOut}, 1, "R7 single event fires");
    step(1, 8'h18, 1, 0);
    ticks(10);
    rd(8'h18, 0, "R7 halted after event");
    step(1, A_CTRL, 32'h7, 0);
    ticks(6);
    rd(8'h18, 0, "R7 rewrite without zero does not re-arm");
    step(1, A_CTRL, 0, 0);
    step(1, A_CTRL, 32'h7, 0);
    ticks(3);
    rd(8'h18, 1, "R7 re-armed after 0 then 1");

    // R9/R10: N=0 masked, clear collides with event
    step(1, A_CTRL, 0, 0);
    step(1, 8'h00, 0, 0);
    step(1, 8'h18, 1, 0);
    step(1, A_CTRL, 32'h1, 0);
    ticks(1);
    rd(8'h18, 1, "R10 flag latches while masked");
    chk({31'b0, irqOut}, 0, "R10 masked irq low");
    step(1, 8'h18, 1, 1);
    rd(8'h18, 1, "R9 event wins over clear");
    step(1, A_CTRL, 0, 0);

    // random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      int r;
      logic tk;
      r  = $urandom % 16;
      tk = ($urandom % 3) == 0;
      if (r == 0)                 step(1, A_CTRL, $urandom % 8, tk);
      else if (r == 1)            step(1, 8'h18, $urandom % 2, tk);
      else if (r == 2 && !mCtrl[0]) step(1, 8'h00, $urandom % 6, tk);
      else                        step(0, 8'h00, 0, tk);
      if (r == 3) begin
        logic [7:0] a;
        a = offs[$urandom % 6];
        rd(a, mRead(a), "R3 random read vs model");
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule